// File: doc/BRIEF.md
# Timer-Clocked SPI Master Shift Engine

This block is the serial engine of an SPI master that has no baud divider of its own. Its bit clock comes from a neighbouring timer channel, and a mode input picks one of two sources. In the first source, every level change of the timer's operating clock becomes one serial clock edge, so the serial clock runs at the timer clock's frequency. In the second source, every underflow pulse of a reload timer becomes one serial clock edge, so one full serial clock period spans two underflows.

Software loads a parallel byte and pulses a start strobe. The engine then shifts the byte out MSB first and shifts the slave's reply in, using the selected clock polarity and phase. When the eighth bit has been captured it raises a one-cycle completion flag, and the received byte is valid from that cycle on. The data input is always an input and the data output is always driven. Slave select is not handled here: general-purpose I/O drives it.

All logic runs on one system clock. The timer clock and the underflow strobe are sampled as synchronous inputs.

Top module: `tclk_spi_master`

## Requirements
- R1: After reset, spiClk, sdo, done and rxData are all 0.
- R2: With noDiv=0, each one-cycle underflow pulse during a transfer produces exactly one spiClk edge, one system clock later. Level changes on tmrClk have no effect in this mode.
- R3: While no transfer is running, spiClk equals cpol, one system clock after cpol is applied.
- R4: With cpha=0, txData bit 7 appears on sdo in the cycle after start is accepted, before the first spiClk edge. sdi is sampled on leading (odd-numbered) edges, and sdo moves to the next bit on each trailing edge except the last.
- R5: With cpha=1, sdo moves to the next bit on each leading edge except the first. sdi is sampled on trailing edges.
- R6: A transfer is 8 bits MSB first and takes exactly 16 spiClk edges. spiClk ends at the cpol level and the engine then accepts a new start.
- R7: done is high for exactly one system clock, the cycle after the eighth sampling edge. rxData then holds the 8 sampled bits, with the first-sampled bit in bit 7.
- R8: A start pulse during a transfer is ignored: the transmitted and received bits are unchanged.
- R9: With noDiv=1 and tmrEnable=1, each level change of tmrClk during a transfer produces exactly one spiClk edge. Underflow pulses have no effect in this mode.
- R10: With noDiv=1 and tmrEnable=0, tmrClk changes produce no spiClk edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| noDiv | input | 1 | 1: timer clock edges drive spiClk; 0: underflow pulses drive spiClk |
| tmrClk | input | 1 | Timer operating clock, sampled as a level |
| tmrEnable | input | 1 | Timer module enable; gates tmrClk in noDiv mode |
| underflow | input | 1 | One-cycle underflow strobe from the reload timer |
| cpol | input | 1 | Idle level of spiClk |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| txData | input | 8 | Byte to transmit |
| start | input | 1 | Start strobe, accepted only when idle |
| sdi | input | 1 | Serial data from the slave |
| sdo | output | 1 | Serial data to the slave |
| spiClk | output | 1 | Serial clock to the slave |
| rxData | output | 8 | Last received byte |
| done | output | 1 | One-cycle pulse when a byte has been received |

## Verification
The bench steps through every spiClk edge in all four polarity and phase modes and in both clock sources. Before each edge it checks the clock level and the data bit, and it checks the completion pulse in the exact cycle after the eighth sampling edge. A design that got the phase wrong would present the data one edge late, or sample the reply on the wrong edge, and return a byte that is shifted by one bit. A design that counted edges wrongly would pulse done early or twice, or leave spiClk off its idle level. Separate scenarios send underflow pulses in pass-through mode, toggle the timer clock in underflow mode or with the enable low, and issue a start during a transfer. A design that let any of these through would move spiClk or change the byte.

// File: rtl/tclk_spi_pkg.sv
package tclk_spi_pkg;
  typedef struct packed {
    logic busy;    // transfer in progress
    logic load;    // accept new word
    logic toggle;  // emit one spiClk edge
    logic shift;   // advance transmit register
    logic sample;  // capture sdi
    logic last;    // final sample of the word
  } spi_strobe_t;
endpackage

// File: rtl/tclk_spi_tick_src.sv
module tclk_spi_tick_src (
  input  logic clk,
  input  logic rstN,
  input  logic noDiv,
  input  logic tmrClk,
  input  logic tmrEnable,
  input  logic underflow,
  output logic tick
);
  logic tmrClkPrev;
  logic passEdge;

  always_ff @(posedge clk) begin
    if (!rstN) tmrClkPrev <= 1'b0;
    else       tmrClkPrev <= tmrClk;
  end

  assign passEdge = tmrEnable & (tmrClk ^ tmrClkPrev);
  assign tick     = noDiv ? passEdge : underflow;

  // R10: a disabled timer never yields an edge in pass-through mode
  p_no_tick_disabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    (noDiv && !tmrEnable) |-> !tick);
endmodule

// File: rtl/tclk_spi_ctl.sv
module tclk_spi_ctl
  import tclk_spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cpha,
  input  logic        tick,
  output spi_strobe_t strb
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES);
  localparam logic [CW-1:0] LAST_EDGE   = CW'(EDGES - 1);
  localparam logic [CW-1:0] LAST_SAMPLE = CW'(EDGES - 2);

  logic          busy;
  logic [CW-1:0] edgeCnt;
  logic          active;
  logic          leading;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      edgeCnt <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      edgeCnt <= '0;
    end else if (busy && tick) begin
      if (edgeCnt == LAST_EDGE) begin
        busy    <= 1'b0;
        edgeCnt <= '0;
      end else begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  assign active  = busy & tick;
  assign leading = ~edgeCnt[0];

  always_comb begin
    strb        = '0;
    strb.busy   = busy;
    strb.load   = start & ~busy;
    strb.toggle = active;
    strb.sample = active & (cpha ? ~leading : leading);
    if (cpha) strb.shift = active & leading & (edgeCnt != '0);
    else      strb.shift = active & ~leading & (edgeCnt != LAST_EDGE);
    strb.last   = strb.sample & (edgeCnt == (cpha ? LAST_EDGE : LAST_SAMPLE));
  end

  // R2: edge count only moves on a timer tick
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> ($stable(edgeCnt) && busy));

  // R6: a transfer ends only after the full edge count
  p_end_after_edges_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(edgeCnt) == LAST_EDGE));

  // R8: a start during a transfer does not restart the count
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !tick) |=> ($stable(edgeCnt)));
endmodule

// File: rtl/tclk_spi_dp.sv
module tclk_spi_dp
  import tclk_spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spi_strobe_t       strb,
  input  logic              cpol,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdi,
  output logic              sdo,
  output logic              spiClk,
  output logic [DATA_W-1:0] rxData,
  output logic              done
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              sclkReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      done    <= 1'b0;
      sclkReg <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.load)        txShift <= txData;
      else if (strb.shift)  txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.load)        rxShift <= '0;
      else if (strb.sample) rxShift <= {rxShift[DATA_W-2:0], sdi};
      if (strb.last) begin
        rxData <= {rxShift[DATA_W-2:0], sdi};
        done   <= 1'b1;
      end
      if (strb.toggle)      sclkReg <= ~sclkReg;
      else if (!strb.busy)  sclkReg <= cpol;
    end
  end

  assign sdo    = txShift[DATA_W-1];
  assign spiClk = sclkReg;

  // R7: completion flag lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: first bit presented right after the load
  p_load_msb_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (sdo == $past(txData[DATA_W-1])));

  // R3: idle clock rests at the polarity level
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.busy) |=> (spiClk == $past(cpol)));
endmodule

// File: rtl/tclk_spi_master.sv
module tclk_spi_master
  import tclk_spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              noDiv,
  input  logic              tmrClk,
  input  logic              tmrEnable,
  input  logic              underflow,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DATA_W-1:0] txData,
  input  logic              start,
  input  logic              sdi,
  output logic              sdo,
  output logic              spiClk,
  output logic [DATA_W-1:0] rxData,
  output logic              done
);
  logic        tick;
  spi_strobe_t strb;

  tclk_spi_tick_src u_tick (
    .clk(clk), .rstN(rstN), .noDiv(noDiv), .tmrClk(tmrClk),
    .tmrEnable(tmrEnable), .underflow(underflow), .tick(tick)
  );

  tclk_spi_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .cpha(cpha),
    .tick(tick), .strb(strb)
  );

  tclk_spi_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpol(cpol), .txData(txData),
    .sdi(sdi), .sdo(sdo), .spiClk(spiClk), .rxData(rxData), .done(done)
  );
endmodule

// File: tb/tclk_spi_master_tb.sv
module tclk_spi_master_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       noDiv = 1'b0;
  logic       tmrClk = 1'b0;
  logic       tmrEnable = 1'b1;
  logic       underflow = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       start = 1'b0;
  logic       sdi = 1'b0;
  logic       sdo, spiClk, done;
  logic [7:0] rxData;

  int total = 0;
  int bad = 0;
  int doneCnt = 0;
  logic [7:0] rxAtDone = 8'h00;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tclk_spi_master u_dut (
    .clk(clk), .rstN(rstN), .noDiv(noDiv), .tmrClk(tmrClk),
    .tmrEnable(tmrEnable), .underflow(underflow), .cpol(cpol), .cpha(cpha),
    .txData(txData), .start(start), .sdi(sdi), .sdo(sdo), .spiClk(spiClk),
    .rxData(rxData), .done(done)
  );

  always @(negedge clk) begin
    if (done === 1'b1) begin
      doneCnt++;
      rxAtDone = rxData;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fireEdge();
    if (noDiv) tmrClk = ~tmrClk;
    else       underflow = 1'b1;
    @(negedge clk);
    underflow = 1'b0;
  endtask

  task automatic pulseStart(input logic [7:0] word);
    @(negedge clk);
    txData = word;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  // Full transfer stepped edge by edge, with a behavioural slave
  task automatic doXfer(input bit srcPass, input bit pol, input bit pha,
                        input logic [7:0] tx, input logic [7:0] slave,
                        input bit injectStart);
    @(negedge clk);
    noDiv = srcPass; cpol = pol; cpha = pha; tmrEnable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(spiClk == pol, "R3 idle level", spiClk, pol);
    doneCnt = 0;
    pulseStart(tx);
    if (!pha) check(sdo == tx[7], "R4 msb before first edge", sdo, tx[7]);
    for (int k = 0; k < 16; k++) begin
      bit isSample;
      int b;
      isSample = pha ? (k % 2 == 1) : (k % 2 == 0);
      b = k / 2;
      check(spiClk == (pol ^ k[0]), srcPass ? "R9 clock level" : "R2 clock level",
            spiClk, pol ^ k[0]);
      if (isSample) begin
        check(sdo == tx[7-b], pha ? "R5 sdo bit" : "R4 sdo bit", sdo, tx[7-b]);
        sdi = slave[7-b];
      end
      if (injectStart && k == 5) begin
        txData = ~tx;
        start  = 1'b1;
      end
      fireEdge();
      start = 1'b0;
      if (isSample && b == 7) check(done == 1'b1, "R7 done after eighth sample", done, 1);
      else                    check(done == 1'b0, "R7 done quiet", done, 0);
      @(negedge clk);
    end
    @(negedge clk);
    check(spiClk == pol, "R6 clock back to idle", spiClk, pol);
    check(doneCnt == 1, "R7 single done pulse", doneCnt, 1);
    check(rxAtDone == slave, injectStart ? "R8 rx unchanged" : "R6 rx byte",
          rxAtDone, slave);
    check(rxData == slave, "R7 rxData held", rxData, slave);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(spiClk == 1'b0, "R1 spiClk", spiClk, 0);
    check(sdo == 1'b0, "R1 sdo", sdo, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(rxData == 8'h00, "R1 rxData", rxData, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(spiClk == 1'b0 && done == 1'b0, "R1 after release", spiClk, 0);
  endtask

  task automatic testIdlePolarity();
    @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    check(spiClk == 1'b1, "R3 follows cpol high", spiClk, 1);
    cpol = 1'b0;
    @(negedge clk);
    check(spiClk == 1'b0, "R3 follows cpol low", spiClk, 0);
  endtask

  task automatic testWrongSource();
    logic heldClk;
    // underflow mode: timer clock toggles ignored
    @(negedge clk);
    noDiv = 1'b0; cpol = 1'b0; cpha = 1'b0; tmrEnable = 1'b1;
    doneCnt = 0;
    pulseStart(8'hC3);
    heldClk = spiClk;
    for (int i = 0; i < 4; i++) begin
      tmrClk = ~tmrClk;
      repeat (2) @(negedge clk);
    end
    check(spiClk == heldClk, "R2 tmrClk ignored", spiClk, heldClk);
    check(sdo == 1'b1, "R2 sdo held at msb", sdo, 1);
    for (int i = 0; i < 16; i++) begin
      fireEdge();
      @(negedge clk);
    end
    check(doneCnt == 1, "R2 finishes on underflows", doneCnt, 1);
    // pass-through mode: underflow ignored, disabled timer ignored
    @(negedge clk);
    noDiv = 1'b1;
    doneCnt = 0;
    pulseStart(8'h3C);
    for (int i = 0; i < 4; i++) begin
      underflow = 1'b1;
      @(negedge clk);
      underflow = 1'b0;
      @(negedge clk);
    end
    check(spiClk == 1'b0, "R9 underflow ignored", spiClk, 0);
    tmrEnable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tmrClk = ~tmrClk;
      repeat (2) @(negedge clk);
    end
    check(spiClk == 1'b0, "R10 disabled timer", spiClk, 0);
    check(sdo == 1'b0, "R10 sdo held", sdo, 0);
    check(doneCnt == 0, "R10 no completion", doneCnt, 0);
    tmrEnable = 1'b1;
    for (int i = 0; i < 16; i++) begin
      fireEdge();
      @(negedge clk);
    end
    check(doneCnt == 1, "R9 finishes on timer clock", doneCnt, 1);
  endtask

  initial begin
    testReset();
    testIdlePolarity();
    doXfer(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
    doXfer(1'b0, 1'b1, 1'b0, 8'h81, 8'hE7, 1'b0);
    doXfer(1'b0, 1'b0, 1'b1, 8'h5A, 8'h96, 1'b0);
    doXfer(1'b0, 1'b1, 1'b1, 8'hFF, 8'h01, 1'b0);
    doXfer(1'b1, 1'b0, 1'b0, 8'h0F, 8'hF0, 1'b0);
    doXfer(1'b1, 1'b1, 1'b1, 8'hC9, 8'h80, 1'b0);
    doXfer(1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0);
    doXfer(1'b0, 1'b0, 1'b0, 8'h96, 8'h69, 1'b1);
    doXfer(1'b1, 1'b1, 1'b0, 8'h37, 8'hB2, 1'b1);
    testWrongSource();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule